// File: doc/BRIEF.md
# Multicycle Datapath with Unified Memory

This block is the datapath half of a 32-bit processor that takes several clock cycles per instruction. One adder-based ALU does every calculation: operand arithmetic, the program counter increment and the branch target. A single word-addressed memory holds both instructions and data. A select line chooses whether the program counter or the stored ALU result addresses it. The block holds the program counter, the instruction register, a memory data register, two operand registers, an ALU result register and a 32-entry register file.

An external sequencer drives the block one cycle at a time. It sets write strobes and operand select codes. In return it receives the opcode and function fields of the current instruction and the zero flag of the live ALU result. Every architectural write is gated by a strobe from the sequencer. The four temporary registers (the two operands, the memory data and the ALU result) are loaded on every clock edge. The testbench fills the memory array before reset is released.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the instruction register and the temporary registers, so opcode and funct read 0 after reset.
- R2: The memory is addressed by the program counter when addr_from_alu is 0 and by the ALU result register when it is 1.
- R3: The first ALU operand is the program counter when opa_reg is 0 and operand register A (the register selected by the rs field) when it is 1.
- R4: opb_sel selects the second ALU operand: 000 operand register B (the register selected by rt), 001 the constant 4, 010 the sign-extended immediate IR[15:0], 011 the sign-extended immediate shifted left by 2, 100 the zero-extended immediate.
- R5: alu_mode selects the ALU operation: 00 add, 01 subtract (first minus second), 11 bitwise OR, 10 follow the function field (0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than, anything else add).
- R6: zero is 1 exactly when the combinational ALU result of the current cycle is zero.
- R7: The program counter loads at a clock edge when pc_wr is 1, or when pc_wr_cond is 1 and zero is 1. It loads the live ALU result when pc_from_reg is 0 and the ALU result register when pc_from_reg is 1. Otherwise it holds.
- R8: The instruction register loads the memory read data only at an edge where ir_wr is 1. opcode is IR[31:26] and funct is IR[5:0].
- R9: At an edge where mem_wr is 1, the memory word selected by address bits [9:2] receives operand register B. Memory never changes at any other edge. Reads are combinational.
- R10: A register file write happens when rf_wr is 1. The destination is rt (IR[20:16]) when rf_dst_rd is 0 and rd (IR[15:11]) when it is 1. The data is the ALU result register when rf_from_mdr is 0 and the memory data register when it is 1. rs is IR[25:21].
- R11: Register 0 always reads as zero, and writes to it are discarded.
- R12: Operand registers A and B, the memory data register and the ALU result register load their sources at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional program counter write |
| pc_wr_cond | input | 1 | Program counter write qualified by zero |
| pc_from_reg | input | 1 | Program counter source: 0 live ALU, 1 ALU result register |
| addr_from_alu | input | 1 | Memory address: 0 program counter, 1 ALU result register |
| mem_wr | input | 1 | Memory write strobe |
| ir_wr | input | 1 | Instruction register load strobe |
| rf_wr | input | 1 | Register file write strobe |
| rf_dst_rd | input | 1 | Write destination: 0 rt, 1 rd |
| rf_from_mdr | input | 1 | Write data: 0 ALU result register, 1 memory data register |
| opa_reg | input | 1 | First operand: 0 program counter, 1 register A |
| opb_sel | input | 3 | Second operand select code |
| alu_mode | input | 2 | ALU operation code |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | Live ALU result equals zero |

## Verification
The bench checks the sign-extended and zero-extended immediates against the same 0x8001 pattern. A design that extends the wrong way makes the equality test flip. It also writes to register 0 and then reads it back through operand A. A design that stores the write makes that compare non-zero. A taken branch and a not-taken branch are each followed by a fetch from a marked word. So a design with a wrong shift on the branch offset, or one that ignores the zero flag, fetches the wrong marker opcode. A store followed by a load with the write strobe low shows whether memory changes only when asked. It also shows whether the instruction register can be loaded from the data address when addr_from_alu is high.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_FUNCT = 2'b10,
    ALU_OR    = 2'b11
  } alu_mode_e;

  typedef enum logic [2:0] {
    OPB_REG     = 3'b000,
    OPB_FOUR    = 3'b001,
    OPB_SEXT    = 3'b010,
    OPB_SEXT_SH = 3'b011,
    OPB_ZEXT    = 3'b100
  } opb_sel_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2a;

endpackage

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  alu_mode_e    mode,
  input  logic [5:0]   fn,
  output logic [W-1:0] y,
  output logic         is_zero
);

  logic [W-1:0] sum, diff;
  logic         lt;

  assign sum  = opa + opb;
  assign diff = opa - opb;
  assign lt   = $signed(opa) < $signed(opb);

  always_comb begin
    unique case (mode)
      ALU_ADD: y = sum;
      ALU_SUB: y = diff;
      ALU_OR:  y = opa | opb;
      default: begin
        case (fn)
          FN_SUB:  y = diff;
          FN_AND:  y = opa & opb;
          FN_OR:   y = opa | opb;
          FN_SLT:  y = {{(W-1){1'b0}}, lt};
          default: y = sum;
        endcase
      end
    endcase
  end

  assign is_zero = (y == '0);

endmodule

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

endmodule

// File: rtl/mcdp_mem.sv
module mcdp_mem #(
  parameter int W     = 32,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] widx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (we) ram[widx] <= wdata;
  end

  assign rdata = ram[widx];

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcdp_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NREG      = 32,
  parameter int MEM_WORDS = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pc_wr,
  input  logic       pc_wr_cond,
  input  logic       pc_from_reg,
  input  logic       addr_from_alu,
  input  logic       mem_wr,
  input  logic       ir_wr,
  input  logic       rf_wr,
  input  logic       rf_dst_rd,
  input  logic       rf_from_mdr,
  input  logic       opa_reg,
  input  logic [2:0] opb_sel,
  input  logic [1:0] alu_mode,
  output logic [5:0] opcode,
  output logic [5:0] funct,
  output logic       zero
);

  localparam int RAW = $clog2(NREG);
  localparam int MAW = $clog2(MEM_WORDS);
  localparam int IMM_W = 16;

  logic [DATA_W-1:0] pc_q, ir_q, a_q, b_q, mdr_q, alu_q;
  logic [DATA_W-1:0] rf_a, rf_b, mem_rdata, mem_addr;
  logic [DATA_W-1:0] opa, opb, alu_y, imm_sext, imm_zext, rf_wdata;
  logic [RAW-1:0]    rs_f, rt_f, rd_f, rf_waddr;
  logic              alu_zero, pc_load;

  // instruction fields
  assign rs_f = ir_q[21 +: RAW];
  assign rt_f = ir_q[16 +: RAW];
  assign rd_f = ir_q[11 +: RAW];
  assign imm_sext = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_zext = {{(DATA_W-IMM_W){1'b0}}, ir_q[IMM_W-1:0]};

  // operand selection
  assign opa = opa_reg ? a_q : pc_q;

  always_comb begin
    unique case (opb_sel_e'(opb_sel))
      OPB_REG:     opb = b_q;
      OPB_FOUR:    opb = DATA_W'(4);
      OPB_SEXT:    opb = imm_sext;
      OPB_SEXT_SH: opb = {imm_sext[DATA_W-3:0], 2'b00};
      OPB_ZEXT:    opb = imm_zext;
      default:     opb = b_q;
    endcase
  end

  mcdp_alu #(.W(DATA_W)) u_alu (
    .opa     (opa),
    .opb     (opb),
    .mode    (alu_mode_e'(alu_mode)),
    .fn      (ir_q[5:0]),
    .y       (alu_y),
    .is_zero (alu_zero)
  );

  // shared memory
  assign mem_addr = addr_from_alu ? alu_q : pc_q;

  mcdp_mem #(.W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_wr),
    .widx  (mem_addr[MAW+1:2]),
    .wdata (b_q),
    .rdata (mem_rdata)
  );

  // register file
  assign rf_waddr = rf_dst_rd ? rd_f : rt_f;
  assign rf_wdata = rf_from_mdr ? mdr_q : alu_q;

  mcdp_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_wr),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs_f),
    .raddr_b (rt_f),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  // state registers
  assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      mdr_q <= '0;
      alu_q <= '0;
    end else begin
      if (pc_load) pc_q <= pc_from_reg ? alu_q : alu_y;
      if (ir_wr)   ir_q <= mem_rdata;
      a_q   <= rf_a;
      b_q   <= rf_b;
      mdr_q <= mem_rdata;
      alu_q <= alu_y;
    end
  end

  assign opcode = ir_q[31:26];
  assign funct  = ir_q[5:0];
  assign zero   = alu_zero;

endmodule

// File: rtl/mcdp_checker.sv
module mcdp_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] pc,
  input logic [W-1:0] ir,
  input logic [W-1:0] a_q,
  input logic [W-1:0] alu_y,
  input logic [W-1:0] mem_rdata,
  input logic         pc_wr,
  input logic         pc_wr_cond,
  input logic         pc_from_reg,
  input logic         ir_wr,
  input logic         zero
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (pc == '0 && ir == '0)); // R1

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(ir)); // R8

  AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst)
    ir_wr |=> (ir == $past(mem_rdata))); // R8

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !(pc_wr_cond && zero)) |=> $stable(pc)); // R7

  AST_PC_LIVE: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && !pc_from_reg) |=> (pc == $past(alu_y))); // R7

  AST_REG0_READ: assert property (@(posedge clk) disable iff (rst)
    (ir[25:21] == 5'd0) |=> (a_q == '0)); // R11

endmodule

bind mc_datapath mcdp_checker #(.W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (pc_q),
  .ir          (ir_q),
  .a_q         (a_q),
  .alu_y       (alu_y),
  .mem_rdata   (mem_rdata),
  .pc_wr       (pc_wr),
  .pc_wr_cond  (pc_wr_cond),
  .pc_from_reg (pc_from_reg),
  .ir_wr       (ir_wr),
  .zero        (zero)
);

// File: tb/test_mc_datapath.sv
module test_mc_datapath;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pc_wr, pc_wr_cond, pc_from_reg, addr_from_alu, mem_wr, ir_wr;
  logic       rf_wr, rf_dst_rd, rf_from_mdr, opa_reg;
  logic [2:0] opb_sel;
  logic [1:0] alu_mode;
  logic [5:0] opcode, funct;
  logic       zero;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mc_datapath i_mc_datapath (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
    .pc_from_reg(pc_from_reg), .addr_from_alu(addr_from_alu), .mem_wr(mem_wr),
    .ir_wr(ir_wr), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .rf_from_mdr(rf_from_mdr),
    .opa_reg(opa_reg), .opb_sel(opb_sel), .alu_mode(alu_mode),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  // scoreboard: 0 = zero flag, 1 = opcode, 2 = funct
  int          kind_q[$];
  string       req_q[$];
  logic [31:0] exp_q[$];
  event        pushed;

  initial begin
    int          k;
    string       r;
    logic [31:0] e, act;
    forever begin
      @(pushed);
      while (kind_q.size() != 0) begin
        k = kind_q.pop_front();
        r = req_q.pop_front();
        e = exp_q.pop_front();
        act = (k == 0) ? {31'd0, zero} : (k == 1) ? {26'd0, opcode} : {26'd0, funct};
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h at %0t", r, k, act, e, $time);
        end
      end
    end
  end

  task automatic expect_item(input int k, input string r, input logic [31:0] e);
    #1;
    kind_q.push_back(k);
    req_q.push_back(r);
    exp_q.push_back(e);
    -> pushed;
    #1;
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; pc_from_reg = 0; addr_from_alu = 0; mem_wr = 0;
    ir_wr = 0; rf_wr = 0; rf_dst_rd = 0; rf_from_mdr = 0; opa_reg = 0;
    opb_sel = 3'b000; alu_mode = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    idle();
  endtask

  task automatic set_alu(input logic a, input logic [2:0] b, input logic [1:0] m);
    opa_reg = a; opb_sel = b; alu_mode = m;
  endtask

  // fetch at PC, PC += 4 from live ALU, then one decode cycle
  task automatic fetch();
    idle();
    ir_wr = 1; pc_wr = 1; set_alu(0, 3'b001, 2'b00);
    tick();
    tick();
  endtask

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) i_mc_datapath.u_mem.ram[i] = 32'h0;
    i_mc_datapath.u_mem.ram[0]  = itype(6'h0d, 5'd0, 5'd5, 16'h8001);
    i_mc_datapath.u_mem.ram[1]  = itype(6'h0d, 5'd5, 5'd0, 16'h8001);
    i_mc_datapath.u_mem.ram[2]  = itype(6'h0d, 5'd0, 5'd0, 16'h0055);
    i_mc_datapath.u_mem.ram[3]  = rtype(5'd5, 5'd0, 5'd7, 6'h25);
    i_mc_datapath.u_mem.ram[4]  = itype(6'h0d, 5'd7, 5'd0, 16'h8001);
    i_mc_datapath.u_mem.ram[5]  = rtype(5'd5, 5'd5, 5'd0, 6'h22);
    i_mc_datapath.u_mem.ram[6]  = itype(6'h2b, 5'd0, 5'd5, 16'h0100);
    i_mc_datapath.u_mem.ram[7]  = itype(6'h23, 5'd0, 5'd9, 16'h0100);
    i_mc_datapath.u_mem.ram[8]  = itype(6'h0d, 5'd9, 5'd0, 16'h8001);
    i_mc_datapath.u_mem.ram[9]  = itype(6'h04, 5'd5, 5'd9, 16'h0002);
    i_mc_datapath.u_mem.ram[10] = itype(6'h3f, 5'd0, 5'd0, 16'h0000);
    i_mc_datapath.u_mem.ram[11] = itype(6'h3e, 5'd0, 5'd0, 16'h0000);
    i_mc_datapath.u_mem.ram[12] = itype(6'h04, 5'd5, 5'd0, 16'h0002);
    i_mc_datapath.u_mem.ram[13] = itype(6'h12, 5'd0, 5'd0, 16'h0010);
    i_mc_datapath.u_mem.ram[14] = itype(6'h3d, 5'd0, 5'd0, 16'h0000);
    i_mc_datapath.u_mem.ram[30] = itype(6'h15, 5'd0, 5'd0, 16'h0000);

    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // reset state
    expect_item(1, "R1", 32'h00);
    expect_item(2, "R1", 32'h00);
    set_alu(0, 3'b000, 2'b00);               // PC(0) + B(0)
    expect_item(0, "R1", 32'h1);

    // w0: r5 = r0 | zext(0x8001)
    fetch();
    expect_item(1, "R8", 32'h0d);
    set_alu(0, 3'b001, 2'b01);               // PC - 4 == 0
    expect_item(0, "R7", 32'h1);
    idle(); set_alu(1, 3'b100, 2'b11); tick();
    rf_wr = 1; tick();

    // w1: compare r5 with zext and sext of 0x8001
    fetch();
    set_alu(1, 3'b100, 2'b01);
    expect_item(0, "R10", 32'h1);
    set_alu(1, 3'b010, 2'b01);
    expect_item(0, "R4", 32'h0);

    // w2: write attempt to register 0
    fetch();
    set_alu(1, 3'b000, 2'b00);               // A(0) + B(0)
    expect_item(0, "R3", 32'h1);
    set_alu(0, 3'b000, 2'b00);               // PC(12) + B(0)
    expect_item(0, "R3", 32'h0);
    idle(); set_alu(1, 3'b100, 2'b11); tick();   // alu_q = 0x55
    rf_wr = 1; tick();
    tick();
    set_alu(1, 3'b000, 2'b00);
    expect_item(0, "R11", 32'h1);

    // w3: r7 = r5 | r0 via function field, written to rd
    fetch();
    expect_item(2, "R8", 32'h25);
    expect_item(1, "R8", 32'h00);
    idle(); set_alu(1, 3'b000, 2'b10); tick();
    rf_wr = 1; rf_dst_rd = 1; tick();

    fetch();                                  // w4
    set_alu(1, 3'b100, 2'b01);
    expect_item(0, "R10", 32'h1);

    // w5: function-field subtract vs plain add
    fetch();
    set_alu(1, 3'b000, 2'b10);
    expect_item(0, "R5", 32'h1);
    set_alu(1, 3'b000, 2'b00);
    expect_item(0, "R12", 32'h0);

    // w6: store r5 to byte address 0x100
    fetch();
    idle(); set_alu(1, 3'b010, 2'b00); tick();
    set_alu(1, 3'b010, 2'b00); addr_from_alu = 1; mem_wr = 1; tick();
    // load instruction register from data address
    set_alu(1, 3'b010, 2'b00); addr_from_alu = 1; ir_wr = 1; tick();
    expect_item(2, "R2", 32'h01);
    expect_item(1, "R2", 32'h00);
    tick();                                   // no ir_wr: must hold
    expect_item(2, "R8", 32'h01);

    // w7: load from 0x100 into r9 (mem_wr low during access)
    fetch();
    idle(); set_alu(1, 3'b010, 2'b00); tick();
    set_alu(1, 3'b010, 2'b00); addr_from_alu = 1; tick();
    rf_wr = 1; rf_from_mdr = 1; tick();

    fetch();                                  // w8
    set_alu(1, 3'b100, 2'b01);
    expect_item(0, "R9", 32'h1);

    // w9: taken branch, PC 40 + (2<<2) = 48
    fetch();
    idle(); set_alu(0, 3'b011, 2'b00); tick();
    set_alu(1, 3'b000, 2'b01); pc_wr_cond = 1; pc_from_reg = 1;
    expect_item(0, "R6", 32'h1);
    tick();
    fetch();                                  // w12
    expect_item(1, "R7", 32'h04);

    // w12: not-taken branch
    idle(); set_alu(0, 3'b011, 2'b00); tick();
    set_alu(1, 3'b000, 2'b01); pc_wr_cond = 1; pc_from_reg = 1;
    expect_item(0, "R6", 32'h0);
    tick();
    fetch();                                  // w13
    expect_item(1, "R7", 32'h12);

    // w13: jump via ALU result register, 56 + (0x10<<2) = 120
    idle(); set_alu(0, 3'b011, 2'b00); tick();
    set_alu(0, 3'b001, 2'b00); pc_wr = 1; pc_from_reg = 1; tick();
    fetch();
    expect_item(1, "R7", 32'h15);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule